// File: doc/BRIEF.md
# Tester Pin Compare and Fail Logger

This block checks the response of a bank of tester channels one vector at a time. Each vector tells every channel whether it drives the device pin or samples it. A driven channel takes a drive level. A sampled channel takes a two-bit expect code: low, high, high-impedance or don't-care. Only the channels flagged in the vector's update mask take new settings. All other channels keep what they had, so a sparse vector only touches the pins that change.

A vector lasts a programmed number of master-clock cycles. In point mode a sampled pin is compared once, in the last cycle of the period. In window mode it is compared in every cycle from a start count for a width count, and any cycle that disagrees fails the pin. Masked pins never fail. When a vector fails, the block counts it in a saturating counter. The first failing vector since start has its index and failing-pin bitmap latched. The block then halts on the first failure, after a programmed number of failures, or never, depending on the stop policy.

A `start` pulse opens a run and clears the index, the count and the record. After that, each vector is accepted with a valid/ready handshake.

Top module: `pin_compare_logger`

## Requirements
- R1: After reset the block is not running (`vec_ready`=0), is not halted, shows no fail, has `fail_count`=0 and `vec_num`=0, drives no pin (`pin_oe`=0), and holds every pin as sampled with the don't-care code.
- R2: Once a vector is accepted, `vec_ready` stays low for exactly `cfg_period` cycles and then rises again. `vec_num` then counts one more completed vector.
- R3: A pin set to drive (`vec_dir` bit 0) has `pin_oe`=1 and shows its level on `pin_drv` from the first cycle of the period. A sampled pin (`vec_dir` bit 1) has `pin_oe`=0.
- R4: A pin whose `vec_upd` bit is 0 keeps its direction, drive level and expect code from the previous vectors.
- R5: In point mode (`cfg_win_mode`=0) a sampled pin is compared only in the last cycle of the period. A mismatch in an earlier cycle does not fail it.
- R6: In window mode the compare covers period counts from `cfg_win_start` to `cfg_win_start+cfg_win_width-1`, where count 0 is the first cycle after acceptance. A mismatch in any one of those cycles fails the pin. Mismatches outside the window are ignored.
- R7: The expect code for pin i sits at `vec_exp[2i+1:2i]`: 0 means low, 1 high, 2 high-impedance, 3 don't-care. Low and high fail if the pin is high-impedance (`pin_z`) or at the other level. Z fails if `pin_z` is 0. Don't-care never fails.
- R8: Driven pins never fail, whatever `pin_in` and `pin_z` show.
- R9: A pin with its `pin_mask` bit set never fails.
- R10: For the first failing vector since start, its index is latched in `fail_vec` and its failing pins in `fail_pins`, and `fail_seen` is set. Later failures leave the record unchanged.
- R11: `fail_count` counts failing vectors and saturates at its maximum value.
- R12: With `cfg_stop_first`=1 the block halts after the first failing vector. Otherwise it halts when `fail_count` reaches `cfg_stop_n`, and a `cfg_stop_n` of 0 means it never halts. While halted, `vec_ready` is 0 and offered vectors are ignored.
- R13: `start` clears the halt, the record, the count and `vec_num`, and makes the block ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | tester master clock |
| rst_n | input | 1 | active-low reset |
| start | input | 1 | opens a run and clears results |
| cfg_period | input | CNT_W | vector period in clocks (at least 1) |
| cfg_win_mode | input | 1 | 0 point compare, 1 window compare |
| cfg_win_start | input | CNT_W | window start count |
| cfg_win_width | input | CNT_W | window width in clocks |
| cfg_stop_first | input | 1 | halt on the first failing vector |
| cfg_stop_n | input | FAIL_W | failure limit, 0 means no limit |
| pin_mask | input | PINS | pins excluded from compare |
| vec_valid | input | 1 | vector offered |
| vec_ready | output | 1 | vector can be accepted |
| vec_upd | input | PINS | pins updated by this vector |
| vec_dir | input | PINS | 1 sample, 0 drive |
| vec_drv | input | PINS | drive levels |
| vec_exp | input | 2*PINS | expect codes |
| pin_in | input | PINS | sampled pin level |
| pin_z | input | PINS | sampled pin is high-impedance |
| pin_oe | output | PINS | channel drive enable |
| pin_drv | output | PINS | channel drive level |
| vec_num | output | VEC_W | completed vectors since start |
| fail_seen | output | 1 | a failing vector was recorded |
| fail_vec | output | VEC_W | index of first failing vector |
| fail_pins | output | PINS | failing pins of that vector |
| fail_count | output | FAIL_W | saturating failing-vector count |
| halted | output | 1 | stop policy reached |

## Verification
The hardest case to reach is a short disturbance on a sampled pin that lands on one exact period count, especially the first and last counts of the window. The bench drives the pin levels on the falling edge, indexed by the period count it has worked out since acceptance. This lets it place a single-cycle glitch just inside or just outside the window, and in point mode on or before the final cycle. Halting at a limit and counter saturation need long runs of failing vectors, so those runs use a one-cycle period.

// File: rtl/pin_compare_logger.sv
module pin_compare_logger #(
  parameter int PINS   = 8,
  parameter int CNT_W  = 8,
  parameter int VEC_W  = 16,
  parameter int FAIL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  cfg_period,
  input  logic              cfg_win_mode,
  input  logic [CNT_W-1:0]  cfg_win_start,
  input  logic [CNT_W-1:0]  cfg_win_width,
  input  logic              cfg_stop_first,
  input  logic [FAIL_W-1:0] cfg_stop_n,
  input  logic [PINS-1:0]   pin_mask,
  input  logic              vec_valid,
  output logic              vec_ready,
  input  logic [PINS-1:0]   vec_upd,
  input  logic [PINS-1:0]   vec_dir,
  input  logic [PINS-1:0]   vec_drv,
  input  logic [2*PINS-1:0] vec_exp,
  input  logic [PINS-1:0]   pin_in,
  input  logic [PINS-1:0]   pin_z,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   pin_drv,
  output logic [VEC_W-1:0]  vec_num,
  output logic              fail_seen,
  output logic [VEC_W-1:0]  fail_vec,
  output logic [PINS-1:0]   fail_pins,
  output logic [FAIL_W-1:0] fail_count,
  output logic              halted
);
  localparam logic [1:0] EXP_LO = 2'd0;
  localparam logic [1:0] EXP_HI = 2'd1;
  localparam logic [1:0] EXP_Z  = 2'd2;
  localparam logic [FAIL_W-1:0] CNT_MAX = '1;

  logic              run_q, halt_q, active_q;
  logic [CNT_W-1:0]  ph_q;
  logic [PINS-1:0]   dir_q, drv_q, acc_q;
  logic [2*PINS-1:0] exp_q, upd2;
  logic [PINS-1:0]   mis, pins_bad;
  logic              last_ph, in_win, load, end_vec, vec_fail, halt_now;
  logic [CNT_W:0]    win_end;
  logic [FAIL_W-1:0] cnt_next;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic [1:0] code;
    logic       bad;
    assign code = exp_q[2*i +: 2];
    always_comb begin
      unique case (code)
        EXP_LO:  bad = pin_z[i] | pin_in[i];
        EXP_HI:  bad = pin_z[i] | ~pin_in[i];
        EXP_Z:   bad = ~pin_z[i];
        default: bad = 1'b0;
      endcase
    end
    assign mis[i] = dir_q[i] & ~pin_mask[i] & bad;
    assign upd2[2*i +: 2] = {2{vec_upd[i]}};
  end

  assign win_end  = {1'b0, cfg_win_start} + {1'b0, cfg_win_width};
  assign last_ph  = ph_q == cfg_period - 1'b1;
  assign in_win   = cfg_win_mode ? ({1'b0, ph_q} >= {1'b0, cfg_win_start} && {1'b0, ph_q} < win_end)
                                 : last_ph;
  assign pins_bad = acc_q | (in_win ? mis : '0);
  assign end_vec  = active_q & last_ph;
  assign vec_fail = end_vec & (|pins_bad);
  assign cnt_next = (fail_count == CNT_MAX) ? CNT_MAX : fail_count + 1'b1;
  assign halt_now = vec_fail & (cfg_stop_first | (cfg_stop_n != '0 && cnt_next >= cfg_stop_n));

  assign vec_ready = run_q & ~active_q;
  assign load      = vec_ready & vec_valid;
  assign halted    = halt_q;
  assign pin_oe    = ~dir_q;
  assign pin_drv   = drv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; halt_q <= 1'b0; active_q <= 1'b0; ph_q <= '0; acc_q <= '0;
      dir_q <= '1; drv_q <= '0; exp_q <= '1;
      vec_num <= '0; fail_seen <= 1'b0; fail_vec <= '0; fail_pins <= '0; fail_count <= '0;
    end else if (start) begin
      run_q <= 1'b1; halt_q <= 1'b0; active_q <= 1'b0; ph_q <= '0; acc_q <= '0;
      vec_num <= '0; fail_seen <= 1'b0; fail_vec <= '0; fail_pins <= '0; fail_count <= '0;
    end else if (load) begin
      active_q <= 1'b1;
      ph_q     <= '0;
      acc_q    <= '0;
      dir_q    <= (vec_upd & vec_dir) | (~vec_upd & dir_q);
      drv_q    <= (vec_upd & vec_drv) | (~vec_upd & drv_q);
      exp_q    <= (upd2 & vec_exp) | (~upd2 & exp_q);
    end else if (active_q) begin
      if (end_vec) begin
        active_q <= 1'b0;
        vec_num  <= vec_num + 1'b1;
        if (vec_fail) begin
          fail_count <= cnt_next;
          if (!fail_seen) begin
            fail_seen <= 1'b1;
            fail_vec  <= vec_num;
            fail_pins <= pins_bad;
          end
        end
        if (halt_now) begin
          run_q  <= 1'b0;
          halt_q <= 1'b1;
        end
      end else begin
        ph_q  <= ph_q + 1'b1;
        acc_q <= pins_bad;
      end
    end
  end

  // R12
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !start) |=> (halted && !vec_ready && $stable(vec_num) && $stable(pin_oe)));

  // R11
  count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> fail_count >= $past(fail_count));

  // R10
  record_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_seen && !start) |=> ($stable(fail_vec) && $stable(fail_pins) && fail_seen));

  // R10
  record_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_seen) |-> (fail_pins != '0 && fail_count != '0));

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ready && vec_valid && !start) |=> !vec_ready);

  // R13
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (vec_ready && !halted && !fail_seen && fail_count == '0 && vec_num == '0));
endmodule

// File: tb/pin_compare_logger_test.sv
`timescale 1ns/1ps
module pin_compare_logger_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  cfg_period = 8'd4;
  logic        cfg_win_mode = 1'b0;
  logic [7:0]  cfg_win_start = 8'd0;
  logic [7:0]  cfg_win_width = 8'd0;
  logic        cfg_stop_first = 1'b0;
  logic [7:0]  cfg_stop_n = 8'd0;
  logic [7:0]  pin_mask = 8'h00;
  logic        vec_valid = 1'b0;
  logic        vec_ready;
  logic [7:0]  vec_upd = 8'h00, vec_dir = 8'h00, vec_drv = 8'h00;
  logic [15:0] vec_exp = 16'h0000;
  logic [7:0]  pin_in = 8'h00, pin_z = 8'h00;
  logic [7:0]  pin_oe, pin_drv, fail_pins;
  logic [15:0] vec_num, fail_vec;
  logic        fail_seen, halted;
  logic [7:0]  fail_count;

  int nchk = 0;
  int nfail = 0;
  logic [7:0] oe0, drv0;

  always #2.5 clk = ~clk;

  pin_compare_logger uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_period(cfg_period),
    .cfg_win_mode(cfg_win_mode), .cfg_win_start(cfg_win_start), .cfg_win_width(cfg_win_width),
    .cfg_stop_first(cfg_stop_first), .cfg_stop_n(cfg_stop_n), .pin_mask(pin_mask),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_upd(vec_upd), .vec_dir(vec_dir),
    .vec_drv(vec_drv), .vec_exp(vec_exp), .pin_in(pin_in), .pin_z(pin_z),
    .pin_oe(pin_oe), .pin_drv(pin_drv), .vec_num(vec_num), .fail_seen(fail_seen),
    .fail_vec(fail_vec), .fail_pins(fail_pins), .fail_count(fail_count), .halted(halted)
  );

  // row: upd dir drv exp in z efail eoe edrv
  localparam logic [79:0] TBL [6] = '{
    {8'hFF, 8'hFF, 8'h00, 16'h5555, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00},
    {8'h00, 8'h00, 8'h00, 16'h0000, 8'hFE, 8'h00, 8'h01, 8'h00, 8'h00},
    {8'h0F, 8'h00, 8'h0A, 16'h0000, 8'hF0, 8'h00, 8'h00, 8'h0F, 8'h0A},
    {8'hF0, 8'hF0, 8'hF0, 16'hE400, 8'h90, 8'h00, 8'h70, 8'h0F, 8'hFA},
    {8'h00, 8'h00, 8'h00, 16'h0000, 8'h20, 8'hC0, 8'h00, 8'h0F, 8'hFA},
    {8'h00, 8'h00, 8'h00, 16'h0000, 8'h20, 8'h60, 8'h20, 8'h0F, 8'hFA}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // at a negedge on entry; returns at the negedge after the period ends
  task automatic run_vec(input logic [7:0] upd, input logic [7:0] dir, input logic [7:0] drv,
                         input logic [15:0] ex, input logic [7:0] vin, input logic [7:0] vz,
                         input int gk, input logic [7:0] gin, input logic [7:0] gz);
    int per;
    per = (cfg_period == 0) ? 1 : int'(cfg_period);
    vec_upd = upd; vec_dir = dir; vec_drv = drv; vec_exp = ex;
    vec_valid = 1'b1;
    @(negedge clk);
    vec_valid = 1'b0;
    for (int k = 0; k < per; k++) begin
      pin_in = vin ^ ((k == gk) ? gin : 8'h00);
      pin_z  = vz  ^ ((k == gk) ? gz  : 8'h00);
      if (k == 0) begin oe0 = pin_oe; drv0 = pin_drv; end
      @(negedge clk);
    end
  endtask

  initial begin
    #200000;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ready", vec_ready, 0);
    check("R1 halted", halted, 0);
    check("R1 seen", fail_seen, 0);
    check("R1 count", fail_count, 0);
    check("R1 vnum", vec_num, 0);
    check("R1 oe", pin_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready before start", vec_ready, 0);

    // table walk: R4 R7 R8 R3
    for (int r = 0; r < 6; r++) begin
      logic [79:0] t;
      t = TBL[r];
      do_start();
      run_vec(t[79:72], t[71:64], t[63:56], t[55:40], t[39:32], t[31:24], -1, 8'h00, 8'h00);
      check($sformatf("R7 R4 R8 row%0d fail_pins", r), fail_pins, t[23:16]);
      check($sformatf("R7 row%0d fail_seen", r), fail_seen, (t[23:16] != 0));
      check($sformatf("R3 row%0d oe", r), oe0, t[15:8]);
      check($sformatf("R3 row%0d drv", r), drv0, t[7:0]);
    end

    // R2 period timing
    do_start();
    vec_upd = 8'h00; vec_valid = 1'b1;
    @(negedge clk);
    vec_valid = 1'b0;
    begin
      int low;
      low = 0;
      while (!vec_ready && low < 50) begin low++; @(negedge clk); end
      check("R2 busy cycles", low, 4);
      check("R2 vec_num", vec_num, 1);
    end

    // set pin0 sampled expect high, others drive
    do_start();
    run_vec(8'hFF, 8'h01, 8'h00, 16'hFFFD, 8'h01, 8'h00, -1, 8'h00, 8'h00);
    // R5 point mode
    do_start();
    run_vec(8'h00, 0, 0, 0, 8'h01, 8'h00, 1, 8'h01, 8'h00);
    check("R5 early glitch ignored", fail_seen, 0);
    do_start();
    run_vec(8'h00, 0, 0, 0, 8'h01, 8'h00, 3, 8'h01, 8'h00);
    check("R5 last cycle fails", fail_pins, 8'h01);

    // R6 window mode, period 8, window counts 2..4
    cfg_period = 8'd8; cfg_win_mode = 1'b1; cfg_win_start = 8'd2; cfg_win_width = 8'd3;
    begin
      int gks [5] = '{1, 2, 4, 5, 7};
      logic [4:0] expf;
      expf = 5'b00110;
      for (int j = 0; j < 5; j++) begin
        do_start();
        run_vec(8'h00, 0, 0, 0, 8'h01, 8'h00, gks[j], 8'h01, 8'h00);
        check($sformatf("R6 glitch at %0d", gks[j]), fail_seen, expf[j]);
      end
    end
    // R7 Z must hold for whole window
    do_start();
    run_vec(8'h01, 8'h01, 8'h00, 16'h0002, 8'h00, 8'h01, 3, 8'h00, 8'h01);
    check("R7 Z window break", fail_pins, 8'h01);
    do_start();
    run_vec(8'h00, 0, 0, 0, 8'h00, 8'h01, -1, 8'h00, 8'h00);
    check("R7 Z held", fail_seen, 0);

    // R9 mask, point mode
    cfg_period = 8'd4; cfg_win_mode = 1'b0;
    do_start();
    run_vec(8'h01, 8'h01, 8'h00, 16'h0001, 8'h00, 8'h00, -1, 8'h00, 8'h00);
    check("R9 unmasked fails", fail_pins, 8'h01);
    pin_mask = 8'h01;
    do_start();
    run_vec(8'h00, 0, 0, 0, 8'h00, 8'h00, -1, 8'h00, 8'h00);
    check("R9 masked no fail", fail_seen, 0);
    pin_mask = 8'h00;

    // R10 R11 R12 halt after 3
    cfg_stop_first = 1'b0; cfg_stop_n = 8'd3;
    do_start();
    run_vec(8'hFF, 8'hFF, 8'h00, 16'h5555, 8'hFF, 8'h00, -1, 0, 0);
    run_vec(8'h00, 0, 0, 0, 8'hFE, 8'h00, -1, 0, 0);
    check("R12 not halted after 1", halted, 0);
    run_vec(8'h00, 0, 0, 0, 8'hFD, 8'h00, -1, 0, 0);
    run_vec(8'h00, 0, 0, 0, 8'hFB, 8'h00, -1, 0, 0);
    check("R12 halted at limit", halted, 1);
    check("R12 ready low", vec_ready, 0);
    check("R10 first vec", fail_vec, 1);
    check("R10 first pins", fail_pins, 8'h01);
    check("R11 count", fail_count, 3);
    run_vec(8'hFF, 8'h00, 8'hAA, 16'h0000, 8'h00, 8'h00, -1, 0, 0);
    check("R12 ignored oe", pin_oe, 8'h00);
    check("R12 ignored vnum", vec_num, 4);

    // R12 stop on first
    cfg_stop_first = 1'b1;
    do_start();
    run_vec(8'h00, 0, 0, 0, 8'hFE, 8'h00, -1, 0, 0);
    check("R12 first halt", halted, 1);
    check("R12 first vnum", vec_num, 1);

    // R13 start clears
    do_start();
    check("R13 ready", vec_ready, 1);
    check("R13 halted", halted, 0);
    check("R13 seen", fail_seen, 0);
    check("R13 count", fail_count, 0);

    // R11 saturation, never halt
    cfg_stop_first = 1'b0; cfg_stop_n = 8'd0; cfg_period = 8'd1;
    for (int n = 0; n < 260; n++)
      run_vec(8'h00, 0, 0, 0, 8'hFE, 8'h00, -1, 0, 0);
    check("R11 saturated", fail_count, 8'hFF);
    check("R12 limit 0 never halts", halted, 0);
    check("R2 vnum after 260", vec_num, 260);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule